// File: doc/BRIEF.md
# Dual-Bank Luma Alignment Pipeline

This block sits between a two-bank video SRAM and a pixel multiplexer that turns one byte into luma samples. In a bus cycle marked for DMA, it takes one byte from the first bank on the rising edge of the bus clock. It takes a second byte from the other bank when a delayed strobe rises about a quarter cycle later. The multiplexer therefore only ever sees one byte per bus cycle. The second-bank byte goes out first. On the next non-DMA cycle the first-bank byte is moved into the output-side register and follows it.

The emitted stream is then pushed through a chain of four bus-cycle delay stages. This makes the luma data line up with the host video chip, which runs four bus cycles behind. Each byte carries a valid flag along the whole path, so the multiplexer can blank any slot whose capture was not selected.

All logic runs on one fast system clock. The bus clock and the second-bank strobe arrive as levels synchronous to it, and the block acts on their rising edges.

Top module: `luma_align_pipe`

## Requirements
- R1: A synchronous active-high reset clears every data register and valid flag. Directly after reset, `luma_q` is 0 and `luma_vld` is 0.
- R2: At a rising edge of `bus_clk` with `dma_slot`=1 and `win_sel_n`=0 (select active low), the byte on `sram_d` is captured as the first-bank byte of that cycle.
- R3: At a rising edge of `bank2_stb` inside a DMA cycle with `win_sel_n`=0, the byte on `sram_d` is captured as the second-bank byte of that cycle.
- R4: The second-bank byte of a DMA cycle is emitted at the next `bus_clk` rising edge. If that next cycle has `dma_slot`=0, the first-bank byte is moved over and emitted at the edge after it.
- R5: A byte emitted at bus edge k appears on `luma_q` just after bus edge k+4. The outputs change only at `bus_clk` rising edges.
- R6: A capture strobe that sees `win_sel_n`=1 inside a DMA cycle leaves that capture register at its previous value and clears its valid flag. The slot that register feeds then shows the old byte with `luma_vld`=0.
- R7: When two DMA cycles follow each other, the first-bank byte of the earlier one is overwritten before it can be transferred, and it is never emitted.
- R8: Each byte's valid flag travels through the delay stages with it. `luma_vld` is 1 exactly for slots holding a freshly selected capture. Idle non-DMA cycles with nothing pending give `luma_vld`=0.
- R9: A `bank2_stb` rising edge in a non-DMA cycle has no effect on the data or valid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all registers run |
| rst | input | 1 | Synchronous reset, active high |
| bus_clk | input | 1 | Bus clock level; its rising edge starts a bus cycle |
| bank2_stb | input | 1 | Delayed strobe; its rising edge captures the second bank |
| sram_d | input | 8 | SRAM read data |
| dma_slot | input | 1 | 1 when the starting bus cycle is a DMA cycle |
| win_sel_n | input | 1 | Active-low select of the memory window |
| luma_q | output | 8 | Aligned luma byte for the pixel multiplexer |
| luma_vld | output | 1 | Valid flag of `luma_q`; 0 means blank |

## Verification
The bench is fed four kinds of bus cycle:
- A DMA cycle followed by idle cycles. This shows the second-then-first emission order and the four-cycle delay.
- DMA cycles back to back. This separates a design that drops the untransferred first-bank byte from one that would queue it.
- DMA cycles with the select inactive at only one of the two strobes. This tells which capture register keeps its old byte, and that only its slot loses the valid flag.
- Non-DMA cycles that still carry strobes and changing data. These show that only DMA cycles load the capture registers.

// File: rtl/luma_align_pkg.sv
package luma_align_pkg;

  localparam int LUMA_W = 8;

  typedef logic [LUMA_W-1:0] luma_byte_t;

  typedef struct packed {
    logic       vld;
    luma_byte_t dat;
  } luma_item_t;

endpackage

// File: rtl/luma_rise_det.sv
module luma_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;

endmodule

// File: rtl/luma_bank_capture.sv
module luma_bank_capture
  import luma_align_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cyc_tick,
  input  logic       b2_tick,
  input  logic       dma,
  input  logic       sel_n,
  input  luma_byte_t din,
  output luma_item_t head,
  output luma_byte_t reg_a,
  output luma_byte_t reg_b,
  output logic       a_pend,
  output logic       b_pend,
  output logic       dma_cyc
);

  // Bus-cycle start: emit the second register, then either load the
  // first register (DMA cycle) or hand it over to the second.
  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      reg_a   <= '0;
      reg_b   <= '0;
      a_pend  <= 1'b0;
      b_pend  <= 1'b0;
      dma_cyc <= 1'b0;
    end else if (cyc_tick) begin
      head    <= '{vld: b_pend, dat: reg_b};
      dma_cyc <= dma;
      if (dma) begin
        b_pend <= 1'b0;
        if (!sel_n) begin
          reg_a  <= din;
          a_pend <= 1'b1;
        end else begin
          a_pend <= 1'b0;
        end
      end else begin
        reg_b  <= reg_a;
        b_pend <= a_pend;
        a_pend <= 1'b0;
      end
    end else if (b2_tick && dma_cyc) begin
      b_pend <= ~sel_n;
      if (!sel_n) reg_b <= din;
    end
  end

endmodule

// File: rtl/luma_delay_line.sv
module luma_delay_line
  import luma_align_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  input  luma_item_t din,
  output luma_item_t dout
);

  luma_item_t stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst)      stg[i] <= '0;
        else if (adv) stg[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst)      stg[i] <= '0;
        else if (adv) stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/luma_align_pipe.sv
module luma_align_pipe
  import luma_align_pkg::*;
#(
  parameter int DELAY_STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_clk,
  input  logic              bank2_stb,
  input  logic [LUMA_W-1:0] sram_d,
  input  logic              dma_slot,
  input  logic              win_sel_n,
  output logic [LUMA_W-1:0] luma_q,
  output logic              luma_vld
);

  logic       cyc_tick;
  logic       b2_tick;
  luma_item_t head;
  luma_item_t tail;
  luma_byte_t reg_a;
  luma_byte_t reg_b;
  logic       a_pend;
  logic       b_pend;
  logic       dma_cyc;

  luma_rise_det u_bus_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (bus_clk),
    .rise (cyc_tick)
  );

  luma_rise_det u_b2_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (bank2_stb),
    .rise (b2_tick)
  );

  luma_bank_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .cyc_tick (cyc_tick),
    .b2_tick  (b2_tick),
    .dma      (dma_slot),
    .sel_n    (win_sel_n),
    .din      (sram_d),
    .head     (head),
    .reg_a    (reg_a),
    .reg_b    (reg_b),
    .a_pend   (a_pend),
    .b_pend   (b_pend),
    .dma_cyc  (dma_cyc)
  );

  luma_delay_line #(
    .STAGES (DELAY_STAGES)
  ) u_dly (
    .clk  (clk),
    .rst  (rst),
    .adv  (cyc_tick),
    .din  (head),
    .dout (tail)
  );

  assign luma_q   = tail.dat;
  assign luma_vld = tail.vld;

endmodule

// File: rtl/luma_align_chk.sv
module luma_align_chk (
  input logic       clk,
  input logic       rst,
  input logic       cyc_tick,
  input logic       b2_tick,
  input logic       dma_slot,
  input logic       win_sel_n,
  input logic       dma_cyc,
  input logic [7:0] reg_a,
  input logic [7:0] reg_b,
  input logic       a_pend,
  input logic       b_pend,
  input logic [7:0] luma_q,
  input logic       luma_vld
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (luma_q == 8'h00 && !luma_vld)); // R1

  AST_A_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cyc_tick && dma_slot && !win_sel_n) |=> a_pend); // R2

  AST_OUT_STILL: assert property (@(posedge clk) disable iff (rst)
    !cyc_tick |=> ($stable(luma_q) && $stable(luma_vld))); // R5

  AST_A_DESEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cyc_tick && dma_slot && win_sel_n) |=> ($stable(reg_a) && !a_pend)); // R6

  AST_B_DESEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (b2_tick && !cyc_tick && dma_cyc && win_sel_n) |=> ($stable(reg_b) && !b_pend)); // R6

  AST_B_IDLE_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (b2_tick && !cyc_tick && !dma_cyc) |=> ($stable(reg_b) && $stable(b_pend))); // R9

endmodule

bind luma_align_pipe luma_align_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_tick  (cyc_tick),
  .b2_tick   (b2_tick),
  .dma_slot  (dma_slot),
  .win_sel_n (win_sel_n),
  .dma_cyc   (dma_cyc),
  .reg_a     (reg_a),
  .reg_b     (reg_b),
  .a_pend    (a_pend),
  .b_pend    (b_pend),
  .luma_q    (luma_q),
  .luma_vld  (luma_vld)
);

// File: tb/test_luma_align_pipe.sv
module test_luma_align_pipe;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_clk = 1'b0;
  logic       bank2_stb = 1'b0;
  logic [7:0] sram_d = 8'h00;
  logic       dma_slot = 1'b0;
  logic       win_sel_n = 1'b1;
  logic [7:0] luma_q;
  logic       luma_vld;

  int total = 0;
  int bad = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  // bus-cycle level model of the requirements
  logic [7:0] m_ra = 8'h00;
  logic [7:0] m_rb = 8'h00;
  logic       m_ap = 1'b0;
  logic       m_bp = 1'b0;

  always #10 clk = ~clk;

  luma_align_pipe i_luma_align_pipe (
    .clk       (clk),
    .rst       (rst),
    .bus_clk   (bus_clk),
    .bank2_stb (bank2_stb),
    .sram_d    (sram_d),
    .dma_slot  (dma_slot),
    .win_sel_n (win_sel_n),
    .luma_q    (luma_q),
    .luma_vld  (luma_vld)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual vld=%0b data=%02h expected vld=%0b data=%02h",
               req, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // driver: one bus cycle of 8 system clocks; pushes the expected head item
  task automatic bus_cycle(input string req, input logic dma, input logic sel_a,
                           input logic sel_b, input logic [7:0] da, input logic [7:0] db);
    @(negedge clk);
    exp_q.push_back({m_bp, m_rb});
    tag_q.push_back(req);
    if (dma) begin
      m_bp = 1'b0;
      if (sel_a) begin
        m_ra = da;
        m_ap = 1'b1;
      end else begin
        m_ap = 1'b0;
      end
    end else begin
      m_rb = m_ra;
      m_bp = m_ap;
      m_ap = 1'b0;
    end
    bus_clk   = 1'b1;
    dma_slot  = dma;
    win_sel_n = !sel_a;
    sram_d    = da;
    repeat (2) @(negedge clk);
    bank2_stb = 1'b1;
    win_sel_n = !sel_b;
    sram_d    = db;
    if (dma) begin
      if (sel_b) begin
        m_rb = db;
        m_bp = 1'b1;
      end else begin
        m_bp = 1'b0;
      end
    end
    repeat (2) @(negedge clk);
    bank2_stb = 1'b0;
    bus_clk   = 1'b0;
    win_sel_n = 1'b1;
    dma_slot  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: one compare per bus edge, sampled on the following falling clock edge
  initial begin
    forever begin
      logic [8:0] e;
      string      t;
      @(posedge bus_clk);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R5: actual vld=%0b data=%02h expected nothing queued", luma_vld, luma_q);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {luma_vld, luma_q}, e);
      end
    end
  end

  initial begin
    #200us;
    total++;
    bad++;
    $display("FAIL watchdog: actual run still active expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: the four delay stages start cleared
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back(9'h000);
      tag_q.push_back("R1");
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {luma_vld, luma_q}, 9'h000);

    // R2 R3 R4: one DMA cycle, then idle; second bank out first
    bus_cycle("R2", 1'b1, 1'b1, 1'b1, 8'hA5, 8'h3C);
    bus_cycle("R3", 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF);
    bus_cycle("R4", 1'b0, 1'b0, 1'b0, 8'h00, 8'hEE);
    // R5: flush through the delay chain
    bus_cycle("R5", 1'b0, 1'b1, 1'b1, 8'h12, 8'h34);
    bus_cycle("R5", 1'b0, 1'b1, 1'b1, 8'h56, 8'h78);

    // R7: back-to-back DMA drops the earlier first-bank byte
    bus_cycle("R7", 1'b1, 1'b1, 1'b1, 8'h11, 8'h22);
    bus_cycle("R7", 1'b1, 1'b1, 1'b1, 8'h33, 8'h44);
    bus_cycle("R7", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    bus_cycle("R7", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);

    // R6: first bank deselected, second selected
    bus_cycle("R6", 1'b1, 1'b0, 1'b1, 8'h55, 8'h66);
    bus_cycle("R6", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    bus_cycle("R6", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);

    // R6: second bank deselected, first selected
    bus_cycle("R6", 1'b1, 1'b1, 1'b0, 8'h77, 8'h88);
    bus_cycle("R6", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    bus_cycle("R6", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);

    // R9: strobes and selects in non-DMA cycles
    bus_cycle("R9", 1'b0, 1'b1, 1'b1, 8'hC3, 8'h9A);
    bus_cycle("R9", 1'b0, 1'b1, 1'b1, 8'h5F, 8'hF5);

    // R8: a final selected DMA cycle, then idle to drain
    bus_cycle("R8", 1'b1, 1'b1, 1'b1, 8'hDE, 8'hAD);
    for (int k = 0; k < 6; k++) bus_cycle("R8", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule